// File: doc/BRIEF.md
# One-Time-Programmable Memory Byte Programming Sequencer

This block writes one byte at a time into an external byte-wide one-time-programmable memory and proves each write. A single start command, carrying a word address and a data byte, launches a fixed sequence. The sequence raises the main supply enable and reads the two identification bytes with the high-voltage enable on address line 9 asserted. If both bytes match, it enables the program-supply switch and fires one timed program pulse on the active-low chip enable while it drives the byte onto the data bus. It then stops driving the bus, reads the byte back in verify mode and compares it. Finally it removes the program supply before the main supply and reports the result.

The memory mode is chosen by the combination of chip enable, output enable, the program-supply enable and the high-voltage enable. The data bus is split into an output half, an input half and a drive enable, so that a pad ring or a test model can join them. All dwell times are counted in clock cycles derived from the clock frequency in MHz.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset and while idle, chip enable and output enable are high, the bus drive enable is low, and the supply, program-supply and high-voltage enables are all low.
- R2: Before any program pulse, the identification bytes are read with chip enable low, output enable low, the high-voltage enable high and the program supply off. Address bit 0 low must return 0x20 and address bit 0 high must return 0x8D. On a mismatch the command ends with the signature-error and fail flags set, and no program pulse is issued.
- R3: The program-supply enable is never high while the main supply enable is low. The main supply stays on for exactly SETTLE_CYC cycles after the program supply turns off.
- R4: The program pulse holds chip enable low for exactly CLK_MHZ*PULSE_US cycles, with output enable high, the program supply on, the bus driven with the data byte, and the address stable.
- R5: The bus drive enable is never high while output enable is low. At least one cycle with chip enable and output enable both high (program inhibit) separates the end of the pulse from the start of verify.
- R6: Verify holds chip enable high and output enable low, with the program supply on, for at least one access time, and samples the bus at its end. If the read byte equals the written byte, the pass flag is set.
- R7: On a verify mismatch, the fail flag is set and the fail address output takes the command address. The supplies are switched off and the sequencer returns to idle.
- R8: Done is a one-cycle pulse at the end of each command. The result flags hold until the next start. A start that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| start | input | 1 | begin a program-and-verify command |
| cmd_addr | input | AW | target word address |
| cmd_data | input | DW | byte to program |
| busy | output | 1 | command in progress |
| done | output | 1 | one-cycle end-of-command pulse |
| pass | output | 1 | last command verified correctly |
| fail | output | 1 | last command failed |
| sig_err | output | 1 | identification bytes did not match |
| fail_addr | output | AW | address of the last failure |
| mem_addr | output | AW | memory address lines |
| dq_out | output | DW | data driven toward the memory |
| dq_in | input | DW | data read from the memory |
| dq_oe | output | 1 | bus drive enable |
| ce_n | output | 1 | active-low chip enable |
| oe_n | output | 1 | active-low output enable |
| vcc_en | output | 1 | main supply switch enable |
| vpp_en | output | 1 | program-supply switch enable |
| a9_hv | output | 1 | high-voltage enable on address line 9 |

## Verification
The bench builds the block with CLK_MHZ=2, ACCESS_NS=500, SETTLE_CYC=4 and AW=8. This gives a 200-cycle program pulse and a 2-cycle verify window, so every phase fits in a few hundred cycles. With a 256-byte memory model that only clears bits, the highest address can be programmed and a re-program that tries to set bits back to 1 forces a genuine verify mismatch. The model can also corrupt either identification byte to drive the abort path.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
    typedef enum logic [3:0] {
        PH_IDLE,
        PH_VCC_UP,
        PH_SIG_LO,
        PH_SIG_HI,
        PH_VPP_UP,
        PH_SETUP,
        PH_PULSE,
        PH_GAP,
        PH_VERIFY,
        PH_VPP_DN
    } phase_t;
endpackage

// File: rtl/otp_dwell_timer.sv
module otp_dwell_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/otp_pin_ctrl.sv
module otp_pin_ctrl
    import otp_seq_pkg::*;
#(
    parameter int AW = 15,
    parameter int DW = 8
) (
    input  phase_t         ph,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  data,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  dq_out,
    output logic           dq_oe,
    output logic           ce_n,
    output logic           oe_n,
    output logic           vcc_en,
    output logic           vpp_en,
    output logic           a9_hv
);
    always_comb begin
        mem_addr = addr;
        dq_out   = data;
        dq_oe    = 1'b0;
        ce_n     = 1'b1;
        oe_n     = 1'b1;
        vcc_en   = (ph != PH_IDLE);
        vpp_en   = 1'b0;
        a9_hv    = 1'b0;
        unique case (ph)
            PH_SIG_LO, PH_SIG_HI: begin
                mem_addr = {{(AW-1){1'b0}}, (ph == PH_SIG_HI)};
                ce_n     = 1'b0;
                oe_n     = 1'b0;
                a9_hv    = 1'b1;
            end
            PH_VPP_UP, PH_GAP: vpp_en = 1'b1;
            PH_SETUP: begin
                vpp_en = 1'b1;
                dq_oe  = 1'b1;
            end
            PH_PULSE: begin
                vpp_en = 1'b1;
                dq_oe  = 1'b1;
                ce_n   = 1'b0;
            end
            PH_VERIFY: begin
                vpp_en = 1'b1;
                oe_n   = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
    import otp_seq_pkg::*;
#(
    parameter int          CLK_MHZ    = 50,
    parameter int          PULSE_US   = 100,
    parameter int          ACCESS_NS  = 45,
    parameter int          SETTLE_CYC = 64,
    parameter int          AW         = 15,
    parameter int          DW         = 8,
    parameter logic [7:0]  MFR_ID     = 8'h20,
    parameter logic [7:0]  DEV_ID     = 8'h8D
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic          fail,
    output logic          sig_err,
    output logic [AW-1:0] fail_addr,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] dq_out,
    input  logic [DW-1:0] dq_in,
    output logic          dq_oe,
    output logic          ce_n,
    output logic          oe_n,
    output logic          vcc_en,
    output logic          vpp_en,
    output logic          a9_hv
);
    localparam int PULSE_CYC = CLK_MHZ * PULSE_US;
    localparam int ACC_CYC   = (ACCESS_NS * CLK_MHZ + 999) / 1000 + 1;
    localparam int MAX_A     = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
    localparam int MAX_CYC   = (MAX_A > ACC_CYC) ? MAX_A : ACC_CYC;
    localparam int TW        = $clog2(MAX_CYC + 1);

    typedef struct packed {
        phase_t        ph;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [AW-1:0] fail_addr;
        logic          done;
        logic          pass;
        logic          fail;
        logic          sig_err;
    } st_t;

    st_t           st_d, st_q;
    logic          t_load, t_exp;
    logic [TW-1:0] t_val;

    otp_dwell_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .load_val(t_val),
        .expired (t_exp)
    );

    otp_pin_ctrl #(.AW(AW), .DW(DW)) u_pins (
        .ph      (st_q.ph),
        .addr    (st_q.addr),
        .data    (st_q.data),
        .mem_addr(mem_addr),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .vcc_en  (vcc_en),
        .vpp_en  (vpp_en),
        .a9_hv   (a9_hv)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        t_load    = 1'b0;
        t_val     = '0;
        unique case (st_q.ph)
            PH_IDLE: if (start) begin
                st_d.ph      = PH_VCC_UP;
                st_d.addr    = cmd_addr;
                st_d.data    = cmd_data;
                st_d.pass    = 1'b0;
                st_d.fail    = 1'b0;
                st_d.sig_err = 1'b0;
                t_load       = 1'b1;
                t_val        = TW'(SETTLE_CYC - 1);
            end
            PH_VCC_UP: if (t_exp) begin
                st_d.ph = PH_SIG_LO;
                t_load  = 1'b1;
                t_val   = TW'(ACC_CYC - 1);
            end
            PH_SIG_LO, PH_SIG_HI: if (t_exp) begin
                t_load = 1'b1;
                if (dq_in[7:0] != ((st_q.ph == PH_SIG_LO) ? MFR_ID : DEV_ID)) begin
                    st_d.ph        = PH_VPP_DN;
                    st_d.fail      = 1'b1;
                    st_d.sig_err   = 1'b1;
                    st_d.fail_addr = st_q.addr;
                    t_val          = TW'(SETTLE_CYC - 1);
                end else if (st_q.ph == PH_SIG_LO) begin
                    st_d.ph = PH_SIG_HI;
                    t_val   = TW'(ACC_CYC - 1);
                end else begin
                    st_d.ph = PH_VPP_UP;
                    t_val   = TW'(SETTLE_CYC - 1);
                end
            end
            PH_VPP_UP: if (t_exp) begin
                st_d.ph = PH_SETUP;
                t_load  = 1'b1;
            end
            PH_SETUP: begin
                st_d.ph = PH_PULSE;
                t_load  = 1'b1;
                t_val   = TW'(PULSE_CYC - 1);
            end
            PH_PULSE: if (t_exp) begin
                st_d.ph = PH_GAP;
                t_load  = 1'b1;
            end
            PH_GAP: begin
                st_d.ph = PH_VERIFY;
                t_load  = 1'b1;
                t_val   = TW'(ACC_CYC - 1);
            end
            PH_VERIFY: if (t_exp) begin
                st_d.ph = PH_VPP_DN;
                t_load  = 1'b1;
                t_val   = TW'(SETTLE_CYC - 1);
                if (dq_in == st_q.data) begin
                    st_d.pass = 1'b1;
                end else begin
                    st_d.fail      = 1'b1;
                    st_d.fail_addr = st_q.addr;
                end
            end
            PH_VPP_DN: if (t_exp) begin
                st_d.ph   = PH_IDLE;
                st_d.done = 1'b1;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign busy      = (st_q.ph != PH_IDLE);
    assign done      = st_q.done;
    assign pass      = st_q.pass;
    assign fail      = st_q.fail;
    assign sig_err   = st_q.sig_err;
    assign fail_addr = st_q.fail_addr;
endmodule

// File: rtl/otp_prog_seq_chk.sv
module otp_prog_seq_chk #(
    parameter int AW        = 15,
    parameter int PULSE_CYC = 5000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          dq_oe,
    input logic          ce_n,
    input logic          oe_n,
    input logic          vcc_en,
    input logic          vpp_en,
    input logic          a9_hv,
    input logic [AW-1:0] mem_addr
);
    int low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                low_cnt <= 0;
        else if (!ce_n && vpp_en)  low_cnt <= low_cnt + 1;
        else if (ce_n)             low_cnt <= 0;
    end

    // R1: quiet pins while reset has just released and nothing runs
    a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_en |-> (ce_n && oe_n && !dq_oe && !vpp_en && !a9_hv));
    a_r2_sig_no_vpp: assert property (@(posedge clk) disable iff (!rst_n)
        a9_hv |-> (!vpp_en && !ce_n && !oe_n && !dq_oe));
    a_r3_vpp_needs_vcc: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_en |-> vcc_en);
    a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ce_n) && $past(vpp_en)) |-> (low_cnt == PULSE_CYC));
    a_r4_pulse_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && vpp_en) |-> (oe_n && dq_oe));
    a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && vpp_en && $past(!ce_n && vpp_en)) |-> $stable(mem_addr));
    a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);
    a_r5_inhibit_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(oe_n) && vpp_en) |-> ($past(ce_n) && $past(!dq_oe)));
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind otp_prog_seq otp_prog_seq_chk #(.AW(AW), .PULSE_CYC(PULSE_CYC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (done),
    .dq_oe   (dq_oe),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .vcc_en  (vcc_en),
    .vpp_en  (vpp_en),
    .a9_hv   (a9_hv),
    .mem_addr(mem_addr)
);

// File: tb/otp_prog_seq_tb.sv
module otp_prog_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ    = 2;
    localparam int PULSE_US   = 100;
    localparam int ACCESS_NS  = 500;
    localparam int SETTLE     = 4;
    localparam int AW         = 8;
    localparam int DW         = 8;
    localparam int PULSE_CYC  = CLK_MHZ * PULSE_US;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic          busy, done, pass, fail, sig_err;
    logic [AW-1:0] fail_addr, mem_addr;
    logic [DW-1:0] dq_out, dq_in;
    logic          dq_oe, ce_n, oe_n, vcc_en, vpp_en, a9_hv;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    otp_prog_seq #(
        .CLK_MHZ(CLK_MHZ), .PULSE_US(PULSE_US), .ACCESS_NS(ACCESS_NS),
        .SETTLE_CYC(SETTLE), .AW(AW), .DW(DW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .busy(busy), .done(done), .pass(pass),
        .fail(fail), .sig_err(sig_err), .fail_addr(fail_addr),
        .mem_addr(mem_addr), .dq_out(dq_out), .dq_in(dq_in), .dq_oe(dq_oe),
        .ce_n(ce_n), .oe_n(oe_n), .vcc_en(vcc_en), .vpp_en(vpp_en), .a9_hv(a9_hv)
    );

    // memory model: erased bytes read 0xFF, programming only clears bits
    logic [DW-1:0] mem [256];
    logic [DW-1:0] rd_q = '0;
    int  bad_sig = 0;
    int  low_cnt = 0, good_pulses = 0, bad_pulses = 0;
    logic [AW-1:0] pa;
    logic [DW-1:0] pd;

    // monitors
    int contention = 0, order_err = 0, done_cnt = 0;
    int vcc_run = 0, vcc_lead = 0, tail_run = 0, vpp_tail = 0;
    int gap_run = 0, last_gap = -1;
    bit after_pulse = 0;
    logic vpp_prev = 0, vcc_prev = 0;

    assign dq_in = rd_q;

    always @(posedge clk) begin
        if (!ce_n && !oe_n && !vpp_en && a9_hv)
            rd_q <= mem_addr[0] ? ((bad_sig == 2) ? 8'h8C : 8'h8D)
                                : ((bad_sig == 1) ? 8'h21 : 8'h20);
        else if (!oe_n && vpp_en && ce_n)
            rd_q <= mem[mem_addr];
        else
            rd_q <= 8'hZZ ^ 8'hZZ;
        if (vpp_en && !ce_n && oe_n && dq_oe) begin
            low_cnt <= low_cnt + 1;
            pa <= mem_addr;
            pd <= dq_out;
        end else if (ce_n && low_cnt > 0) begin
            if (low_cnt == PULSE_CYC) begin
                mem[pa] <= mem[pa] & pd;
                good_pulses <= good_pulses + 1;
            end else bad_pulses <= bad_pulses + 1;
            low_cnt <= 0;
        end
        if (dq_oe && !oe_n) contention <= contention + 1;
        if (vpp_en && !vcc_en) order_err <= order_err + 1;
        if (done) done_cnt <= done_cnt + 1;
        vpp_prev <= vpp_en;
        vcc_prev <= vcc_en;
        vcc_run  <= (vcc_en && !vpp_en) ? vcc_run + 1 : 0;
        if (vpp_en && !vpp_prev) vcc_lead <= vcc_run;
        tail_run <= vpp_en ? 0 : (vcc_en ? tail_run + 1 : tail_run);
        if (!vcc_en && vcc_prev) vpp_tail <= tail_run;
        if (vpp_en && !ce_n) begin after_pulse <= 1; gap_run <= 0; end
        else if (after_pulse && ce_n && oe_n) gap_run <= gap_run + 1;
        if (after_pulse && !oe_n && vpp_en) begin last_gap <= gap_run; after_pulse <= 0; end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int n = 0;
        @(negedge clk);
        cmd_addr = a; cmd_data = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        chk("R8 done seen", int'(done), 1);
        @(negedge clk);
        chk("R8 done one cycle", int'(done), 0);
    endtask

    task automatic t_reset;
        chk("R1 ce_n", int'(ce_n), 1);
        chk("R1 oe_n", int'(oe_n), 1);
        chk("R1 dq_oe", int'(dq_oe), 0);
        chk("R1 vcc_en", int'(vcc_en), 0);
        chk("R1 vpp_en", int'(vpp_en), 0);
        chk("R1 a9_hv", int'(a9_hv), 0);
        chk("R1 busy", int'(busy), 0);
    endtask

    task automatic t_good(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int gp = good_pulses;
        run_cmd(a, d);
        chk("R6 pass", int'(pass), 1);
        chk("R6 no fail", int'(fail), 0);
        chk("R4 one full pulse", good_pulses - gp, 1);
        chk("R4 no short pulse", bad_pulses, 0);
        chk("R4 byte stored", int'(mem[a]), int'(d));
        chk("R3 vcc leads vpp", int'(vcc_lead >= SETTLE), 1);
        chk("R3 vcc tail", vpp_tail, SETTLE);
        chk("R5 inhibit gap", last_gap, 1);
        chk("R1 idle after", int'(vcc_en | vpp_en | busy), 0);
    endtask

    task automatic t_mismatch;
        run_cmd(8'h10, 8'hA5);
        chk("R7 fail", int'(fail), 1);
        chk("R7 no pass", int'(pass), 0);
        chk("R7 fail_addr", int'(fail_addr), 'h10);
        chk("R7 supplies off", int'(vcc_en | vpp_en), 0);
        repeat (5) @(negedge clk);
        chk("R8 flags held", int'(fail), 1);
    endtask

    task automatic t_badsig(input int which);
        int gp = good_pulses;
        bad_sig = which;
        run_cmd(8'h40, 8'h00);
        bad_sig = 0;
        chk("R2 sig_err", int'(sig_err), 1);
        chk("R2 fail", int'(fail), 1);
        chk("R2 no pulse", good_pulses - gp, 0);
        chk("R2 byte untouched", int'(mem[8'h40]), 'hFF);
        chk("R2 supplies off", int'(vcc_en | vpp_en), 0);
    endtask

    task automatic t_busy_start;
        int n = 0, dc;
        @(negedge clk);
        cmd_addr = 8'h20; cmd_data = 8'h33; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        dc = done_cnt;
        cmd_addr = 8'h30; cmd_data = 8'h00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        repeat (30) @(negedge clk);
        chk("R8 single done", done_cnt - dc, 1);
        chk("R8 busy start ignored", int'(mem[8'h30]), 'hFF);
        chk("R8 first cmd ok", int'(mem[8'h20]), 'h33);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_good(8'h10, 8'h5A);
        t_good(8'hFF, 8'h00);
        t_good(8'h01, 8'hFF);
        t_mismatch();
        t_badsig(1);
        t_badsig(2);
        t_good(8'h7E, 8'h81);
        t_busy_start();
        chk("R5 no contention", contention, 0);
        chk("R3 order", order_err, 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R8 actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule